// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a register-mapped mailbox that sits between a host processor and an auxiliary controller core. The host loads up to four words of input data and two address pointers, then writes a command word. An accepted command sets a hardware busy flag and sends a one-cycle notification pulse to the controller. The controller reads the command, the pointers and the input words, fills a four-word result buffer, and then signals completion with an error flag and an error code. The host polls a status word for busy, error, the echoed command id, its own initiator id and the error code. If the command asked for it, the host also gets a one-cycle completion interrupt.

The host side uses a plain single-cycle register bus with no back-pressure. A write with `h_wr` and a read with `h_rd` each complete in the cycle they are presented. Read data is combinational from the decoded address. Write effects become visible after the next rising clock edge. All controller-side signals are plain level or pulse pins. A command that arrives while the mailbox is busy is dropped and recorded in a sticky overrun flag.

Top module: `ipc_mailbox`

## Requirements
- R1: Byte map on `h_addr`. Command is at 0x00, status at 0x04, source pointer at 0x08 and destination pointer at 0x0C. The input buffer is at 0x80, 0x84, 0x88 and 0x8C, and the result buffer is at 0x90, 0x94, 0x98 and 0x9C. The host can read back the pointers and the input buffer after writing them.
- R2: Command word fields: code [7:0], completion-request flag [8] and command id [15:12]; bits [23:16] carry a size. An accepted command write sets busy and presents the whole word on `c_cmd`. It puts the command id in status [7:4] and `h_init_id` in status [15:8], and it clears status error [1] and error code [23:16]. Status busy is bit [0].
- R3: `c_irq` is high for exactly the one cycle after each accepted command write, and for no other cycle.
- R4: A host write whose byte enables are not all ones changes no register and starts no command.
- R5: While busy, `c_done` clears busy and loads status error from `c_err` and status code from `c_err_code`. Both are held until the next accepted command. `c_done` has no effect while idle.
- R6: `h_done_irq` is high for the one cycle after a completion whose command had bit [8] set. It stays low when that bit was clear.
- R7: A command write while busy is ignored: no `c_irq`, and status and `c_cmd` are unchanged. It sets `c_overrun`. An effective completion clears `c_overrun` unless a rejected write falls in the same cycle, in which case the flag stays set.
- R8: Reads of the command address, of the reserved words between 0x10 and 0x7C, and of unmapped words return zero. Host writes to the result buffer and to status are ignored.
- R9: The controller sees `c_sptr`, `c_dptr` and the input word selected by `c_wbuf_idx` directly. With `c_rbuf_we` high, it writes `c_rbuf_data` into result word `c_rbuf_idx`, and the host can read that word after the next edge.
- R10: After reset, every register reads zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | ADDR_W | Host byte address |
| h_be | input | 4 | Host byte enables |
| h_wdata | input | 32 | Host write data |
| h_init_id | input | 8 | Initiator id captured with each command |
| h_rdata | output | 32 | Host read data, zero when not reading |
| h_done_irq | output | 1 | Completion interrupt pulse to host |
| c_irq | output | 1 | New-command pulse to controller |
| c_cmd | output | 32 | Last accepted command word |
| c_busy | output | 1 | Mailbox busy |
| c_overrun | output | 1 | Sticky rejected-command flag |
| c_sptr | output | 32 | Source pointer |
| c_dptr | output | 32 | Destination pointer |
| c_wbuf_idx | input | log2(BUF_WORDS) | Input-buffer word select |
| c_wbuf_data | output | 32 | Selected input-buffer word |
| c_rbuf_we | input | 1 | Result-buffer write enable |
| c_rbuf_idx | input | log2(BUF_WORDS) | Result-buffer word select |
| c_rbuf_data | input | 32 | Result-buffer write data |
| c_done | input | 1 | Completion strobe |
| c_err | input | 1 | Error flag supplied with completion |
| c_err_code | input | 8 | Error code supplied with completion |

## Verification
The controller's completion strobe and a new host command write can fall in the same cycle. The bench forces this overlap by issuing a command, then presenting `c_done` together with a second full command write. Because busy is judged at the start of the cycle, that write must be rejected. The behavioural model therefore expects busy to clear, the completion's error to land in status, no `c_irq`, and `c_overrun` to stay set. The random phase then lets such collisions recur freely under per-cycle comparison.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;
  localparam int DATA_W      = 32;
  localparam int BE_W        = DATA_W / 8;
  // command word fields
  localparam int CMD_IOC_BIT = 8;
  localparam int CMD_ID_LSB  = 12;
  localparam int CMD_ID_W    = 4;
  // status word fields
  localparam int ST_BUSY     = 0;
  localparam int ST_ERR      = 1;
  localparam int ST_ID_LSB   = 4;
  localparam int ST_INIT_LSB = 8;
  localparam int ST_CODE_LSB = 16;
  localparam int INIT_W      = 8;
  localparam int CODE_W      = 8;
  // word indices on the host map
  localparam int W_CMD       = 0;
  localparam int W_STAT      = 1;
  localparam int W_SPTR      = 2;
  localparam int W_DPTR      = 3;
  localparam int W_INBUF     = 32;

  typedef struct packed {
    logic cmd;
    logic stat;
    logic sptr;
    logic dptr;
    logic inbuf;
    logic outbuf;
  } mbx_hit_t;
endpackage

// File: rtl/ipc_mbx_decode.sv
module ipc_mbx_decode
  import ipc_mbx_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BUF_WORDS = 4,
  localparam int IDX_W    = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  output mbx_hit_t          hit,
  output logic [IDX_W-1:0]  idx,
  output logic              full_be
);
  localparam int WORD_W    = ADDR_W - 2;
  localparam int OUT_BASE  = W_INBUF + BUF_WORDS;

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] in_off;
  logic [WORD_W-1:0] out_off;

  always_comb begin
    word    = addr[ADDR_W-1:2];
    in_off  = word - WORD_W'(W_INBUF);
    out_off = word - WORD_W'(OUT_BASE);
    full_be = &be;
    hit        = '0;
    hit.cmd    = (word == WORD_W'(W_CMD));
    hit.stat   = (word == WORD_W'(W_STAT));
    hit.sptr   = (word == WORD_W'(W_SPTR));
    hit.dptr   = (word == WORD_W'(W_DPTR));
    hit.inbuf  = (word >= WORD_W'(W_INBUF)) && (word < WORD_W'(OUT_BASE));
    hit.outbuf = (word >= WORD_W'(OUT_BASE)) && (word < WORD_W'(OUT_BASE + BUF_WORDS));
    idx        = hit.outbuf ? out_off[IDX_W-1:0] : in_off[IDX_W-1:0];
  end

  // R1: one address selects at most one register
  assert_onehot_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: rtl/ipc_mbx_regfile.sv
module ipc_mbx_regfile
  import ipc_mbx_pkg::*;
#(
  parameter int BUF_WORDS = 4,
  localparam int IDX_W    = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr,
  input  logic              full_be,
  input  mbx_hit_t          hit,
  input  logic [IDX_W-1:0]  h_idx,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic [IDX_W-1:0]  c_wbuf_idx,
  input  logic              c_rbuf_we,
  input  logic [IDX_W-1:0]  c_rbuf_idx,
  input  logic [DATA_W-1:0] c_rbuf_data,
  output logic [DATA_W-1:0] sptr,
  output logic [DATA_W-1:0] dptr,
  output logic [DATA_W-1:0] h_inbuf_rd,
  output logic [DATA_W-1:0] h_outbuf_rd,
  output logic [DATA_W-1:0] c_wbuf_data
);
  logic              wr_ok;
  logic [DATA_W-1:0] inbuf  [BUF_WORDS];
  logic [DATA_W-1:0] outbuf [BUF_WORDS];

  assign wr_ok = h_wr && full_be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sptr <= '0;
      dptr <= '0;
    end else begin
      if (wr_ok && hit.sptr) sptr <= h_wdata;
      if (wr_ok && hit.dptr) dptr <= h_wdata;
    end
  end

  for (genvar g = 0; g < BUF_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        inbuf[g]  <= '0;
        outbuf[g] <= '0;
      end else begin
        if (wr_ok && hit.inbuf && h_idx == IDX_W'(g)) inbuf[g] <= h_wdata;
        if (c_rbuf_we && c_rbuf_idx == IDX_W'(g))     outbuf[g] <= c_rbuf_data;
      end
    end
  end

  assign h_inbuf_rd  = inbuf[h_idx];
  assign h_outbuf_rd = outbuf[h_idx];
  assign c_wbuf_data = inbuf[c_wbuf_idx];

  // R4: a partial-enable write leaves the pointers alone
  assert_partial_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && !full_be) |=> ($stable(sptr) && $stable(dptr)));
endmodule

// File: rtl/ipc_mbx_ctrl.sv
module ipc_mbx_ctrl
  import ipc_mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic [INIT_W-1:0] h_init_id,
  input  logic              c_done,
  input  logic              c_err,
  input  logic [CODE_W-1:0] c_err_code,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] cmd_q,
  output logic              busy,
  output logic              c_irq,
  output logic              h_done_irq,
  output logic              overrun
);
  logic                accept, reject, done_eff;
  logic                err_q, ioc_q;
  logic [CMD_ID_W-1:0] cid_q;
  logic [INIT_W-1:0]   init_q;
  logic [CODE_W-1:0]   code_q;

  assign accept   = cmd_wr && !busy;
  assign reject   = cmd_wr && busy;
  assign done_eff = c_done && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      err_q      <= 1'b0;
      ioc_q      <= 1'b0;
      cid_q      <= '0;
      init_q     <= '0;
      code_q     <= '0;
      cmd_q      <= '0;
      c_irq      <= 1'b0;
      h_done_irq <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      c_irq      <= accept;
      h_done_irq <= done_eff && ioc_q;
      if (accept) begin
        busy   <= 1'b1;
        cmd_q  <= h_wdata;
        ioc_q  <= h_wdata[CMD_IOC_BIT];
        cid_q  <= h_wdata[CMD_ID_LSB +: CMD_ID_W];
        init_q <= h_init_id;
        err_q  <= 1'b0;
        code_q <= '0;
      end else if (done_eff) begin
        busy   <= 1'b0;
        err_q  <= c_err;
        code_q <= c_err_code;
      end
      if (reject)        overrun <= 1'b1;
      else if (done_eff) overrun <= 1'b0;
    end
  end

  always_comb begin
    status                             = '0;
    status[ST_BUSY]                    = busy;
    status[ST_ERR]                     = err_q;
    status[ST_ID_LSB +: CMD_ID_W]      = cid_q;
    status[ST_INIT_LSB +: INIT_W]      = init_q;
    status[ST_CODE_LSB +: CODE_W]      = code_q;
  end

  assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    c_irq |=> !c_irq);
  assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !c_done) |=> busy);
  assert_done_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    h_done_irq |-> (!busy && $past(busy)));
  assert_reject_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> (overrun && $stable(cmd_q) && !c_irq));
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbx_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BUF_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         h_wr,
  input  logic                         h_rd,
  input  logic [ADDR_W-1:0]            h_addr,
  input  logic [3:0]                   h_be,
  input  logic [31:0]                  h_wdata,
  input  logic [7:0]                   h_init_id,
  output logic [31:0]                  h_rdata,
  output logic                         h_done_irq,
  output logic                         c_irq,
  output logic [31:0]                  c_cmd,
  output logic                         c_busy,
  output logic                         c_overrun,
  output logic [31:0]                  c_sptr,
  output logic [31:0]                  c_dptr,
  input  logic [$clog2(BUF_WORDS)-1:0] c_wbuf_idx,
  output logic [31:0]                  c_wbuf_data,
  input  logic                         c_rbuf_we,
  input  logic [$clog2(BUF_WORDS)-1:0] c_rbuf_idx,
  input  logic [31:0]                  c_rbuf_data,
  input  logic                         c_done,
  input  logic                         c_err,
  input  logic [7:0]                   c_err_code
);
  localparam int IDX_W = $clog2(BUF_WORDS);

  mbx_hit_t          hit;
  logic [IDX_W-1:0]  idx;
  logic              full_be;
  logic [DATA_W-1:0] status, in_rd, out_rd;

  ipc_mbx_decode #(.ADDR_W(ADDR_W), .BUF_WORDS(BUF_WORDS)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(h_addr), .be(h_be),
    .hit(hit), .idx(idx), .full_be(full_be));

  ipc_mbx_regfile #(.BUF_WORDS(BUF_WORDS)) u_regs (
    .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .full_be(full_be), .hit(hit),
    .h_idx(idx), .h_wdata(h_wdata), .c_wbuf_idx(c_wbuf_idx),
    .c_rbuf_we(c_rbuf_we), .c_rbuf_idx(c_rbuf_idx), .c_rbuf_data(c_rbuf_data),
    .sptr(c_sptr), .dptr(c_dptr), .h_inbuf_rd(in_rd), .h_outbuf_rd(out_rd),
    .c_wbuf_data(c_wbuf_data));

  ipc_mbx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_wr(h_wr && full_be && hit.cmd),
    .h_wdata(h_wdata), .h_init_id(h_init_id), .c_done(c_done), .c_err(c_err),
    .c_err_code(c_err_code), .status(status), .cmd_q(c_cmd), .busy(c_busy),
    .c_irq(c_irq), .h_done_irq(h_done_irq), .overrun(c_overrun));

  // command word is write-only; reserved space reads zero
  always_comb begin
    h_rdata = '0;
    if (h_rd) begin
      unique case (1'b1)
        hit.stat:   h_rdata = status;
        hit.sptr:   h_rdata = c_sptr;
        hit.dptr:   h_rdata = c_dptr;
        hit.inbuf:  h_rdata = in_rd;
        hit.outbuf: h_rdata = out_rd;
        default:    h_rdata = '0;
      endcase
    end
  end

  assert_idle_rdata_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_rd || hit.cmd) |-> (h_rdata == '0));
endmodule

// File: tb/ipc_mailbox_test.sv
module ipc_mailbox_test;
  logic        clk = 0, rst_n = 0;
  logic        h_wr = 0, h_rd = 0;
  logic [7:0]  h_addr = 0;
  logic [3:0]  h_be = 0;
  logic [31:0] h_wdata = 0;
  logic [7:0]  h_init_id = 0;
  logic [31:0] h_rdata, c_cmd, c_sptr, c_dptr, c_wbuf_data;
  logic        h_done_irq, c_irq, c_busy, c_overrun;
  logic [1:0]  c_wbuf_idx = 0, c_rbuf_idx = 0;
  logic        c_rbuf_we = 0, c_done = 0, c_err = 0;
  logic [31:0] c_rbuf_data = 0;
  logic [7:0]  c_err_code = 0;

  int n_run = 0, n_fail = 0, cycles = 0;

  always #5 clk = ~clk;

  ipc_mailbox uut (.*);

  // behavioural reference
  logic        m_busy, m_err, m_ioc, m_cirq, m_dirq, m_ovr;
  logic [3:0]  m_cid;
  logic [7:0]  m_init, m_code;
  logic [31:0] m_cmd, m_sptr, m_dptr;
  logic [31:0] m_wbuf [4];
  logic [31:0] m_rbuf [4];

  always @(posedge clk) begin : model
    int w; bit full, wcmd, acc, rej, dn;
    if (!rst_n) begin
      m_busy = 0; m_err = 0; m_ioc = 0; m_cirq = 0; m_dirq = 0; m_ovr = 0;
      m_cid = 0; m_init = 0; m_code = 0; m_cmd = 0; m_sptr = 0; m_dptr = 0;
      for (int i = 0; i < 4; i++) begin m_wbuf[i] = 0; m_rbuf[i] = 0; end
    end else begin
      w = int'(h_addr[7:2]);
      full = h_wr && (h_be == 4'hF);
      wcmd = full && w == 0;
      acc = wcmd && !m_busy;
      rej = wcmd && m_busy;
      dn  = c_done && m_busy;
      m_cirq = acc;
      m_dirq = dn && m_ioc;
      if (acc) begin
        m_busy = 1; m_cmd = h_wdata; m_ioc = h_wdata[8]; m_cid = h_wdata[15:12];
        m_init = h_init_id; m_err = 0; m_code = 0;
      end else if (dn) begin
        m_busy = 0; m_err = c_err; m_code = c_err_code;
      end
      if (rej) m_ovr = 1; else if (dn) m_ovr = 0;
      if (full && w == 2) m_sptr = h_wdata;
      if (full && w == 3) m_dptr = h_wdata;
      if (full && w >= 32 && w < 36) m_wbuf[w-32] = h_wdata;
      if (c_rbuf_we) m_rbuf[c_rbuf_idx] = c_rbuf_data;
    end
  end

  function automatic logic [31:0] mread(input logic [7:0] a);
    int w = int'(a[7:2]);
    if (w == 1) return {8'h0, m_code, m_init, m_cid, 2'b0, m_err, m_busy};
    if (w == 2) return m_sptr;
    if (w == 3) return m_dptr;
    if (w >= 32 && w < 36) return m_wbuf[w-32];
    if (w >= 36 && w < 40) return m_rbuf[w-36];
    return 0;
  endfunction

  function automatic string rtag(input logic [7:0] a);
    int w = int'(a[7:2]);
    if (w == 1) return "R2_R5 status";
    if (w == 2 || w == 3 || (w >= 32 && w < 36)) return "R1 readback";
    if (w >= 36 && w < 40) return "R9 result buffer";
    return "R8 zero read";
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic compare();
    chk("R3 c_irq", 32'(c_irq), 32'(m_cirq));
    chk("R6 h_done_irq", 32'(h_done_irq), 32'(m_dirq));
    chk("R7 c_overrun", 32'(c_overrun), 32'(m_ovr));
    chk("R2 c_busy", 32'(c_busy), 32'(m_busy));
    chk("R2 c_cmd", c_cmd, m_cmd);
    chk("R9 c_sptr", c_sptr, m_sptr);
    chk("R9 c_dptr", c_dptr, m_dptr);
    chk("R9 c_wbuf_data", c_wbuf_data, m_wbuf[c_wbuf_idx]);
    if (h_rd) chk(rtag(h_addr), h_rdata, mread(h_addr));
  endtask

  task automatic idle();
    h_wr = 0; h_rd = 0; h_be = 0; c_done = 0; c_rbuf_we = 0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    compare();
    idle();
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    h_wr = 1; h_addr = a; h_wdata = d; h_be = be; tick();
  endtask

  task automatic hread(input logic [7:0] a);
    h_rd = 1; h_addr = a; tick();
  endtask

  initial begin : wdog
    while (cycles < 200000) begin @(posedge clk); cycles++; end
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R10 reset state
    chk("R10 busy", 32'(c_busy), 0);
    chk("R10 irqs", 32'({c_irq, h_done_irq, c_overrun}), 0);
    hread(8'h04); chk("R10 status", h_rdata, 0);
    hread(8'h90); chk("R10 result word", h_rdata, 0);

    // R1 pointer and input buffer readback
    hwrite(8'h08, 32'h1111_0000); hwrite(8'h0C, 32'h2222_0000);
    for (int i = 0; i < 4; i++) hwrite(8'h80 + 8'(4*i), 32'hA000_0000 + i);
    hread(8'h08); hread(8'h0C); hread(8'h88);

    // R4 partial enables change nothing
    hwrite(8'h08, 32'hDEAD_BEEF, 4'b0111);
    hread(8'h08); chk("R4 sptr kept", h_rdata, 32'h1111_0000);
    h_init_id = 8'h42;
    hwrite(8'h00, 32'h0004_513A, 4'b1110);
    chk("R4 no command", 32'({c_busy, c_irq}), 0);

    // R2 R3 accepted command with completion request
    hwrite(8'h00, 32'h0004_513A);
    chk("R3 irq after accept", 32'(c_irq), 1);
    hread(8'h04); chk("R2 status fields", h_rdata, 32'h0000_4251);
    chk("R3 irq single", 32'(c_irq), 0);
    c_wbuf_idx = 2; tick(); chk("R9 wbuf word2", c_wbuf_data, 32'hA000_0002);
    hread(8'h00); chk("R8 cmd reads zero", h_rdata, 0);

    // R7 command while busy
    hwrite(8'h00, 32'h0000_7001);
    chk("R7 overrun set", 32'(c_overrun), 1);
    chk("R7 cmd kept", c_cmd, 32'h0004_513A);

    // R9 R5 R6 result and completion
    c_rbuf_we = 1; c_rbuf_idx = 1; c_rbuf_data = 32'h5A5A_0001; tick();
    c_done = 1; c_err = 1; c_err_code = 8'h55; tick();
    chk("R6 done irq", 32'(h_done_irq), 1);
    chk("R7 overrun cleared", 32'(c_overrun), 0);
    hread(8'h04); chk("R5 status after done", h_rdata, 32'h0055_4252);
    hread(8'h94); chk("R9 result readback", h_rdata, 32'h5A5A_0001);

    // collision: done with rejected write in the same cycle (R7), ioc clear (R6)
    hwrite(8'h00, 32'h0000_2010);
    c_done = 1; c_err = 0; c_err_code = 8'h07;
    h_wr = 1; h_addr = 8'h00; h_be = 4'hF; h_wdata = 32'h0000_3111; tick();
    chk("R7 collision overrun kept", 32'(c_overrun), 1);
    chk("R6 no irq without request", 32'(h_done_irq), 0);
    chk("R7 collision no c_irq", 32'(c_irq), 0);
    c_done = 1; c_err = 1; c_err_code = 8'hEE; tick();
    hread(8'h04); chk("R5 done while idle ignored", h_rdata, 32'h0007_4220);

    // R8 reserved space, writes to result buffer and status ignored
    hwrite(8'h98, 32'hFFFF_FFFF); hwrite(8'h04, 32'hFFFF_FFFF);
    hread(8'h98); chk("R8 result not host-writable", h_rdata, 0);
    hread(8'h10); hread(8'h40); hread(8'h7C); hread(8'hFC);

    // random phase with per-cycle comparison
    for (int n = 0; n < 3000; n++) begin
      int op = $urandom_range(0, 9);
      h_addr = {6'($urandom_range(0, 41)), 2'b00};
      if ($urandom_range(0, 5) == 0) h_addr = 8'h00;
      h_wdata = $urandom; h_init_id = 8'($urandom);
      c_wbuf_idx = 2'($urandom); c_rbuf_idx = 2'($urandom); c_rbuf_data = $urandom;
      c_err = 1'($urandom); c_err_code = 8'($urandom);
      c_done = ($urandom_range(0, 4) == 0);
      c_rbuf_we = ($urandom_range(0, 3) == 0);
      if (op < 4) begin h_wr = 1; h_be = 4'hF; end
      else if (op == 4) begin h_wr = 1; h_be = 4'($urandom_range(0, 14)); end
      else h_rd = 1;
      tick();
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule